// File: doc/BRIEF.md
# Fully Associative Tag and Data Store with Rotating-Pointer Replacement

This block is the storage and lookup side of a small fully associative cache. A word address comes in on the lookup port. The block address is that word address with the in-block word bits removed, and it is compared against the stored tag of every entry at the same time. One cycle later the port returns a hit or a miss. On a hit it also returns the addressed word of the matching block. No index field exists: any block may occupy any entry, and each stored tag is the complete block address.

When a lookup misses, the memory side fetches the block and writes it in through the fill port. The block names the entry that the next fill will use, and the memory side can read it. While any entry is still invalid, fills take the lowest-numbered invalid entry, so nothing valid is evicted before the store is full. Once every entry is valid, the victim is the entry named by a single replacement pointer. That pointer steps forward only when the entry it names is used, which approximates least-recently-used at the cost of one small counter. A flush input empties the store.

Top module: `fa_tag_store`

## Requirements
- R1: The block address is `addr >> OFF_W` with `OFF_W = log2(BLK_WORDS)` (2 by default). The low `OFF_W` address bits select the word within the block. The tag comparison uses the complete block address, so two addresses that differ in any bit above the offset are different blocks.
- R2: A lookup compares all entries in parallel, and at most one entry matches. On a hit, `rsp_data` is word `addr[OFF_W-1:0]` of the block stored in the matching entry.
- R3: An entry whose valid bit is clear never matches. After reset or flush, every lookup misses.
- R4: While at least one entry is invalid, `victim_slot` names the lowest-numbered invalid entry, and a fill writes there. No valid entry is overwritten while the store is not full.
- R5: After reset all valid bits are clear, the replacement pointer is 0, and `victim_slot` is 0.
- R6: The replacement pointer advances by one, wrapping from `ENTRIES-1` to 0, when a lookup hits the entry the pointer names. A hit on any other entry, or a miss, leaves the pointer unchanged.
- R7: When every entry is valid, `victim_slot` equals the replacement pointer, and a fill replaces that entry.
- R8: A fill written into the entry the pointer names advances the pointer by one, with wrap, so the new block is not the next victim.
- R9: `rsp_valid`, `rsp_hit` and `rsp_data` are registered. They reflect a lookup presented in one cycle at the next clock edge. `rsp_valid` is low in the cycle after a cycle with no lookup.
- R10: `flush` clears every valid bit and returns the pointer to 0 at the next edge, and it takes priority over a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Word address to look up |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | DATA_W | Addressed word on a hit, zero on a miss |
| fill_valid | input | 1 | Write a block into `victim_slot` |
| fill_addr | input | ADDR_W | Any word address inside the block being filled |
| fill_block | input | BLK_WORDS*DATA_W | Block contents, word 0 in the low bits |
| flush | input | 1 | Invalidate all entries and reset the pointer |
| victim_slot | output | log2(ENTRIES) | Entry the next fill will write |

## Verification
The bench builds the block with its default parameters: 64 entries, 32-bit word addresses and data, and four-word blocks. This lets it fill the full 64 distinct blocks and confirm that none is evicted. It then walks the pointer through every entry, including the wrap from 63 back to 0. The full tag width lets the bench hit with the same low bits but a flipped top address bit, so aliasing is checked. The four-word blocks put every word position of the data select within reach.

// File: rtl/fa_store_pkg.sv
package fa_store_pkg;

  // Next value of a modulo-n ring counter.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // Block address of a word address: drop the in-block word bits.
  function automatic logic [63:0] block_of(input logic [63:0] addr, input int unsigned off_w);
    return addr >> off_w;
  endfunction

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned BLK_W   = 30
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][BLK_W-1:0] tags,
  input  logic [BLK_W-1:0]              probe,
  output logic [ENTRIES-1:0]            hit_vec
);
  // One comparator per entry; an invalid entry is masked off.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (tags[i] == probe);
  end
endmodule

// File: rtl/fa_word_sel.sv
module fa_word_sel #(
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned BLK_WORDS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned OFF_W    = $clog2(BLK_WORDS)
) (
  input  logic [ENTRIES-1:0]                          sel,
  input  logic [ENTRIES-1:0][BLK_WORDS-1:0][DATA_W-1:0] blocks,
  input  logic [OFF_W-1:0]                            word_off,
  output logic [DATA_W-1:0]                           word
);
  // AND-OR select driven by the one-hot match vector.
  always_comb begin
    word = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      word = word | (blocks[i][word_off] & {DATA_W{sel[i]}});
    end
  end
endmodule

// File: rtl/fa_victim.sv
module fa_victim
  import fa_store_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic               lk_fire,
  input  logic               fill_fire,
  input  logic               flush,
  output logic [IDX_W-1:0]   victim,
  output logic [IDX_W-1:0]   ptr
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             hit_at_ptr;
  logic             fill_at_ptr;
  logic [IDX_W-1:0] ptr_step;

  assign free_any = ~&valid;

  // Lowest-numbered invalid entry.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim      = free_any ? free_idx : ptr_q;
  assign hit_at_ptr  = lk_fire && hit_vec[ptr_q];
  assign fill_at_ptr = fill_fire && (victim == ptr_q);
  assign ptr_step    = IDX_W'(ring_next(32'(ptr_q), ENTRIES));
  assign ptr         = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush)                ptr_q <= '0;
    else if (hit_at_ptr || fill_at_ptr) ptr_q <= ptr_step;
  end

  // R4: with free space, the chosen victim is an invalid entry.
  assert_free_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && free_any) |-> !valid[victim]);

  // R7: with no free space, the victim is the pointer entry.
  assert_full_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !free_any) |-> (victim == ptr_q));

  // R6: a hit on the pointed entry moves the pointer one step on.
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && hit_vec[ptr_q] && !flush) |=>
      (32'(ptr_q) == ring_next(32'($past(ptr_q)), ENTRIES)));

  // R6/R8: no touch of the pointed entry, no movement.
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(lk_fire && hit_vec[ptr_q]) && !(fill_fire && victim == ptr_q))
      |=> $stable(ptr_q));
endmodule

// File: rtl/fa_tag_store.sv
module fa_tag_store
  import fa_store_pkg::*;
#(
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BLK_WORDS = 4,
  localparam int unsigned OFF_W    = $clog2(BLK_WORDS),
  localparam int unsigned BLK_W    = ADDR_W - OFF_W,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [ADDR_W-1:0]           lk_addr,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic [DATA_W-1:0]           rsp_data,
  input  logic                        fill_valid,
  input  logic [ADDR_W-1:0]           fill_addr,
  input  logic [BLK_WORDS*DATA_W-1:0] fill_block,
  input  logic                        flush,
  output logic [IDX_W-1:0]            victim_slot
);
  logic [ENTRIES-1:0]                            valid_q;
  logic [ENTRIES-1:0][BLK_W-1:0]                 tag_q;
  logic [ENTRIES-1:0][BLK_WORDS-1:0][DATA_W-1:0] data_q;

  logic [BLK_W-1:0]   lk_blk;
  logic [BLK_W-1:0]   fill_blk;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] hit_vec;
  logic [DATA_W-1:0]  sel_word;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   ptr;
  logic               fill_do;

  assign lk_blk   = BLK_W'(block_of(64'(lk_addr), OFF_W));
  assign fill_blk = BLK_W'(block_of(64'(fill_addr), OFF_W));
  assign lk_off   = lk_addr[OFF_W-1:0];
  assign fill_do  = fill_valid && !flush;

  fa_tag_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_match (
    .valid  (valid_q),
    .tags   (tag_q),
    .probe  (lk_blk),
    .hit_vec(hit_vec)
  );

  fa_word_sel #(.ENTRIES(ENTRIES), .BLK_WORDS(BLK_WORDS), .DATA_W(DATA_W)) u_sel (
    .sel     (hit_vec),
    .blocks  (data_q),
    .word_off(lk_off),
    .word    (sel_word)
  );

  fa_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid_q),
    .hit_vec  (hit_vec),
    .lk_fire  (lk_valid),
    .fill_fire(fill_do),
    .flush    (flush),
    .victim   (victim),
    .ptr      (ptr)
  );

  assign victim_slot = victim;

  // Valid bits: reset and flush clear, fill sets.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) valid_q <= '0;
    else if (fill_do)    valid_q[victim] <= 1'b1;
  end

  // Tag and data arrays carry no reset; valid guards them.
  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[victim]  <= fill_blk;
      data_q[victim] <= fill_block;
    end
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|hit_vec);
      rsp_data  <= lk_valid ? sel_word : '0;
    end
  end

  // R2: never more than one matching entry.
  assert_onehot_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(hit_vec));

  // R9: response appears exactly one cycle after a request.
  assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_resp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R3: a reported hit means some entry was valid at the request.
  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && valid_q == '0) |=> !rsp_hit);

  // R10: flush empties the store and rewinds the pointer.
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0 && ptr == '0));

  // R4: a fill leaves its entry valid.
  assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> valid_q[$past(victim)]);
endmodule

// File: tb/fa_tag_store_test.sv
`timescale 1ns/1ps
module fa_tag_store_test;
  localparam int N = 64;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_data;
  logic fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [BW*DW-1:0] fill_block = '0;
  logic flush = 1'b0;
  logic [IW-1:0] victim_slot;

  int n_tests = 0;
  int n_fail = 0;

  // Reference model state.
  bit m_valid [N];
  logic [29:0] m_blk [N];
  int m_ptr = 0;

  always #2 clk = ~clk;

  fa_tag_store uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_block(fill_block),
    .flush(flush), .victim_slot(victim_slot)
  );

  function automatic logic [31:0] dval(input logic [29:0] blk, input int w);
    return ({blk, 2'b00} * 32'd2654435) ^ 32'(w) ^ 32'hC0DE0000;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    return m_ptr;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_blk[i] = '0; end
    m_ptr = 0;
  endtask

  // Lookup: drive at a falling edge, sample one cycle later (R9).
  task automatic do_lookup(input logic [31:0] a, input string req);
    int idx;
    idx = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_blk[i] == a[31:2]) idx = i;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9", "rsp_valid", longint'(rsp_valid), 1);
    chk(rsp_hit == (idx >= 0), req, "hit", longint'(rsp_hit), longint'(idx >= 0));
    if (idx >= 0)
      chk(rsp_data == dval(a[31:2], int'(a[1:0])), "R2", "data",
          longint'(rsp_data), longint'(dval(a[31:2], int'(a[1:0]))));
    if (idx >= 0 && idx == m_ptr) m_ptr = (m_ptr + 1) % N;
    chk(int'(victim_slot) == model_victim(), "R6", "victim after lookup",
        longint'(victim_slot), longint'(model_victim()));
  endtask

  task automatic do_fill(input logic [29:0] blk);
    int v;
    v = model_victim();
    @(negedge clk);
    chk(int'(victim_slot) == v, (m_valid[v] ? "R7" : "R4"), "victim before fill",
        longint'(victim_slot), longint'(v));
    fill_valid = 1'b1; fill_addr = {blk, 2'b11};
    for (int w = 0; w < BW; w++) fill_block[w*DW +: DW] = dval(blk, w);
    @(negedge clk);
    fill_valid = 1'b0;
    m_valid[v] = 1; m_blk[v] = blk;
    if (v == m_ptr) m_ptr = (m_ptr + 1) % N;
    chk(int'(victim_slot) == model_victim(), "R8", "victim after fill",
        longint'(victim_slot), longint'(model_victim()));
  endtask

  function automatic logic [29:0] blk_of_i(input int i);
    return 30'h1000 + 30'(i * 3);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(victim_slot == '0, "R5", "victim at reset", longint'(victim_slot), 0);
    chk(rsp_valid == 1'b0, "R9", "idle rsp_valid", longint'(rsp_valid), 0);
    do_lookup(32'h0, "R3");
    do_lookup({blk_of_i(0), 2'b00}, "R3");
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < N; i++) begin
      do_lookup({blk_of_i(i), 2'b01}, "R4");
      do_fill(blk_of_i(i));
    end
    for (int i = 0; i < N; i++) do_lookup({blk_of_i(i), 2'(i)}, "R4");
  endtask

  task automatic t_tag_width();
    do_lookup({~blk_of_i(5)[29], blk_of_i(5)[28:0], 2'b00}, "R1");
    for (int w = 0; w < BW; w++) do_lookup({blk_of_i(7), 2'(w)}, "R1");
  endtask

  task automatic t_pointer_walk();
    // Hit on a non-pointer entry: no move.
    do_lookup({m_blk[(m_ptr + 5) % N], 2'b10}, "R6");
    // Walk the pointer all the way round, through the wrap.
    for (int k = 0; k < N + 2; k++) do_lookup({m_blk[m_ptr], 2'(k)}, "R6");
  endtask

  task automatic t_replace();
    for (int k = 0; k < 3; k++) begin
      logic [29:0] old_blk;
      logic [29:0] nb;
      old_blk = m_blk[m_ptr];
      nb = 30'h2_0000 + 30'(k);
      do_lookup({nb, 2'b00}, "R7");
      do_fill(nb);
      do_lookup({old_blk, 2'b00}, "R7");
      do_lookup({nb, 2'b10}, "R7");
    end
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_addr = 32'hFFFF_FFF0;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    model_reset();
    chk(victim_slot == '0, "R10", "victim after flush", longint'(victim_slot), 0);
    do_lookup({blk_of_i(10), 2'b00}, "R10");
    do_lookup(32'hFFFF_FFF0, "R10");
    do_fill(30'h3_1234);
    do_lookup({30'h3_1234, 2'b11}, "R10");
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_all();
    t_tag_width();
    t_pointer_walk();
    t_replace();
    t_flush();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule